// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block runs the peripheral I/O space of a processor core. The core makes a dedicated I/O read or write by raising a request with an address, a direction flag and write data. The block then drives the external I/O select and one strobe for the whole access. It stalls the core by holding ready low until the final cycle of the access. The I/O space holds 2048 sixteen-bit locations. Only the low eleven address bits reach the external bus.

The number of inserted wait cycles depends on the quarter of the I/O space that the access falls in. Each quarter has its own 3-bit wait code. One global stretch bit selects how a code becomes a wait count: a count of N when the bit is clear, and 2N+1 when it is set. This gives a range of 0 to 15 waits. The codes and the stretch bit sit in a small register port. After reset they hold the slowest setting, so slow peripherals work before software changes anything.

Top module: `io_wait_gen`

## Requirements
- R1: After reset, all four wait codes read back 7 and the stretch bit reads back 1 through the configuration port.
- R2: With the stretch bit clear, an access whose region code is N keeps io_sel high for exactly N+1 cycles.
- R3: With the stretch bit set, an access whose region code is N keeps io_sel high for exactly 2N+2 cycles, which is 2N+1 waits.
- R4: The region is address bits 10:9: 0 for 0x000–0x1FF, 1 for 0x200–0x3FF, 2 for 0x400–0x5FF and 3 for 0x600–0x7FF. Configuration addresses 0 to 3 hold the codes of regions 0 to 3.
- R5: core_ready is high while no access runs. During an access it is low in every cycle except the last one in which io_sel is high.
- R6: A read (req_wr=0) raises io_rd and keeps io_wr low while io_sel is high. The io_rdata value present in the last cycle appears on core_rdata once io_sel has dropped.
- R7: A write (req_wr=1) raises io_wr and keeps io_rd low, and io_wdata equals the request's write data in every cycle that io_sel is high.
- R8: io_addr equals req_addr bits 10:0 for the whole access. Bits 13:11 of req_addr have no effect on io_addr or on the wait count.
- R9: A request that is held high while an access runs starts no new access. io_sel stays low after the access ends once req has dropped.
- R10: The wait count is fixed when the access starts. A configuration write during the access does not change the length of that access.
- R11: Configuration address 4 holds the stretch bit in data bit 0. Addresses 5 to 7 read 0, and writes to them change no code or stretch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | I/O access request from the core, taken when the block is idle |
| req_addr | input | 14 | Core address; bits 10:0 select the I/O location |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data from the core |
| core_ready | output | 1 | Low while the core must stall |
| core_rdata | output | 16 | Read data captured at the end of a read |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 3 | Configuration write data |
| cfg_rdata | output | 3 | Configuration read data for cfg_addr |
| io_sel | output | 1 | External I/O select |
| io_rd | output | 1 | External read strobe |
| io_wr | output | 1 | External write strobe |
| io_addr | output | 11 | External I/O address |
| io_wdata | output | 16 | External write data |
| io_rdata | input | 16 | External read data |

## Verification
Accesses are made to every region after the four codes are set to different values (0, 3, 5 and 7). A region decoded wrongly therefore shows up as a wrong select length. The same codes are then tried with the stretch bit set and clear, which separates the N and 2N+1 mappings, and code 0 covers the zero-wait edge. Further accesses set the upper address bits, hold the request high through the whole access, or rewrite the active region's code mid-access. These show that the address is truncated, that a held request does not retrigger, and that the wait count is latched. Reads and writes are both made, so strobe choice, write data hold and the point of read capture are each checked.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = CODE_W + 1;

  // stretched count 2N+1 is the code with a one appended below it
  function automatic logic [CNT_W-1:0] wait_count(input logic [CODE_W-1:0] code,
                                                  input logic stretch);
    return stretch ? {code, 1'b1} : {1'b0, code};
  endfunction
endpackage

// File: rtl/io_wait_regs.sv
module io_wait_regs #(
  parameter int NREG   = 4,
  parameter int CODE_W = 3,
  parameter int CFG_AW = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [CODE_W-1:0]            cfg_wdata,
  output logic [CODE_W-1:0]            cfg_rdata,
  output logic [NREG-1:0][CODE_W-1:0]  codes,
  output logic                         stretch
);
  localparam int SEL_W = $clog2(NREG);

  logic [NREG-1:0][CODE_W-1:0] code_q;
  logic                        stretch_q;

  for (genvar g = 0; g < NREG; g++) begin : g_code
    always_ff @(posedge clk) begin
      if (rst)
        code_q[g] <= '1;
      else if (cfg_we && cfg_addr == CFG_AW'(g))
        code_q[g] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      stretch_q <= 1'b1;
    else if (cfg_we && cfg_addr == CFG_AW'(NREG))
      stretch_q <= cfg_wdata[0];
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < CFG_AW'(NREG))
      cfg_rdata = code_q[cfg_addr[SEL_W-1:0]];
    else if (cfg_addr == CFG_AW'(NREG))
      cfg_rdata = CODE_W'(stretch_q);
  end

  assign codes   = code_q;
  assign stretch = stretch_q;

  // R1
  reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&code_q && stretch_q));

  // R11
  cfg_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(code_q) && $stable(stretch_q)));
endmodule

// File: rtl/io_wait_seq.sv
module io_wait_seq
  import io_wait_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_AW  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [IO_AW-1:0]  req_addr,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  wait_n,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  output logic              io_sel,
  output logic              io_rd,
  output logic              io_wr,
  output logic [IO_AW-1:0]  io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      io_sel     <= 1'b0;
      io_rd      <= 1'b0;
      io_wr      <= 1'b0;
      io_addr    <= '0;
      io_wdata   <= '0;
      core_rdata <= '0;
    end else if (!busy_q) begin
      if (req) begin
        busy_q   <= 1'b1;
        cnt_q    <= wait_n;
        io_sel   <= 1'b1;
        io_rd    <= !req_wr;
        io_wr    <= req_wr;
        io_addr  <= req_addr;
        io_wdata <= req_wdata;
      end
    end else if (last) begin
      busy_q <= 1'b0;
      io_sel <= 1'b0;
      io_rd  <= 1'b0;
      io_wr  <= 1'b0;
      if (io_rd) core_rdata <= io_rdata;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign core_ready = !busy_q || last;

  // R5
  ready_end_chk: assert property (@(posedge clk) disable iff (rst)
    (io_sel && core_ready) |=> !io_sel);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr) && ((io_rd || io_wr) == io_sel));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_sel && $past(io_sel) && !$past(core_ready)) |-> $stable(io_addr));

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && $past(io_wr) && !$past(core_ready)) |-> $stable(io_wdata));

  // R5
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !io_sel |-> core_ready);
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
  import io_wait_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_AW  = 11,
  parameter int BUS_AW = 14,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  output logic [CODE_W-1:0] cfg_rdata,
  output logic              io_sel,
  output logic              io_rd,
  output logic              io_wr,
  output logic [IO_AW-1:0]  io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata
);
  localparam int SEL_W = $clog2(NREG);

  logic [NREG-1:0][CODE_W-1:0] codes;
  logic                        stretch;
  logic [SEL_W-1:0]            region;
  logic [CNT_W-1:0]            wait_n;
  logic                        unused_hi;

  assign unused_hi = ^req_addr[BUS_AW-1:IO_AW];
  assign region    = req_addr[IO_AW-1 -: SEL_W];
  assign wait_n    = wait_count(codes[region], stretch);

  io_wait_regs #(.NREG(NREG), .CODE_W(CODE_W), .CFG_AW(3)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .codes(codes), .stretch(stretch)
  );

  io_wait_seq #(.DATA_W(DATA_W), .IO_AW(IO_AW)) i_seq (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr[IO_AW-1:0]),
    .req_wr(req_wr), .req_wdata(req_wdata), .wait_n(wait_n),
    .core_ready(core_ready), .core_rdata(core_rdata), .io_sel(io_sel),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata)
  );
endmodule

// File: tb/test_io_wait_gen.sv
module test_io_wait_gen;
  logic        clk = 0;
  logic        rst = 1;
  logic        req = 0;
  logic [13:0] req_addr = '0;
  logic        req_wr = 0;
  logic [15:0] req_wdata = '0;
  logic        core_ready;
  logic [15:0] core_rdata;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [2:0]  cfg_wdata = '0;
  logic [2:0]  cfg_rdata;
  logic        io_sel, io_rd, io_wr;
  logic [10:0] io_addr;
  logic [15:0] io_wdata;
  logic [15:0] io_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int shadow [4];
  int mode_sh;

  io_wait_gen i_io_wait_gen (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_wr(req_wr),
    .req_wdata(req_wdata), .core_ready(core_ready), .core_rdata(core_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 3'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input int a, output int d);
    cfg_addr = 3'(a);
    #1;
    d = int'(cfg_rdata);
  endtask

  function automatic int exp_waits(input int n, input int m);
    return m ? 2 * n + 1 : n;
  endfunction

  // measures one access: select cycles, ready-low cycles, strobe/data/address conformity
  task automatic do_access(input logic [13:0] a, input bit wr, input logic [15:0] wd,
                           input logic [15:0] rdv, input bit hold, input bit mid_cfg,
                           output int selc, output int rdyl, output bit stb_ok,
                           output bit dat_ok, output bit adr_ok, output bit last_rdy);
    selc = 0; rdyl = 0; stb_ok = 1; dat_ok = 1; adr_ok = 1; last_rdy = 0;
    @(negedge clk);
    req = 1; req_addr = a; req_wr = wr; req_wdata = wd; io_rdata = rdv;
    @(negedge clk);
    if (!hold) req = 0;
    for (int guard = 0; guard < 40 && io_sel; guard++) begin
      selc++;
      if (!core_ready) rdyl++;
      last_rdy = core_ready;
      if (io_rd != !wr || io_wr != wr) stb_ok = 0;
      if (wr && io_wdata != wd) dat_ok = 0;
      if (io_addr != a[10:0]) adr_ok = 0;
      if (mid_cfg && selc == 1) begin
        cfg_we = 1; cfg_addr = {1'b0, a[10:9]}; cfg_wdata = 3'd0;
      end else begin
        cfg_we = 0;
      end
      @(negedge clk);
    end
    req = 0; cfg_we = 0;
  endtask

  task automatic t_reset;
    int d;
    for (int i = 0; i < 4; i++) begin
      cfg_read(i, d);
      check(d == 7, "R1 wait code reset", d, 7);
    end
    cfg_read(4, d);
    check(d == 1, "R1 stretch reset", d, 1);
    check(core_ready == 1, "R5 idle ready", int'(core_ready), 1);
    check(io_sel == 0, "R5 idle select", int'(io_sel), 0);
  endtask

  task automatic t_regions(input int m);
    int sc, rl; bit so, dok, aok, lr;
    for (int r = 0; r < 4; r++) begin
      for (int w = 0; w < 2; w++) begin
        logic [15:0] rv = 16'h1000 + 16'(r * 16 + w);
        logic [15:0] wv = 16'hA500 + 16'(r);
        do_access(14'((r << 9) | 13), w[0], wv, rv, 0, 0, sc, rl, so, dok, aok, lr);
        if (m) check(sc == exp_waits(shadow[r], m) + 1, "R3 stretched length", sc, exp_waits(shadow[r], m) + 1);
        else   check(sc == exp_waits(shadow[r], m) + 1, "R2 R4 region length", sc, exp_waits(shadow[r], m) + 1);
        check(rl == exp_waits(shadow[r], m) && lr, "R5 ready low cycles", rl, exp_waits(shadow[r], m));
        if (w == 1) begin
          check(so, "R7 write strobes", int'(so), 1);
          check(dok, "R7 write data held", int'(dok), 1);
        end else begin
          check(so, "R6 read strobes", int'(so), 1);
          check(core_rdata == rv, "R6 read data", int'(core_rdata), int'(rv));
        end
        check(aok, "R8 address", int'(aok), 1);
      end
    end
  endtask

  task automatic t_upper_addr;
    int sc, rl; bit so, dok, aok, lr;
    do_access(14'h3A05, 0, 16'h0, 16'h5A5A, 0, 0, sc, rl, so, dok, aok, lr);
    check(aok, "R8 upper bits dropped", int'(io_addr), 11'h205);
    check(sc == exp_waits(shadow[1], mode_sh) + 1, "R8 region from low bits", sc,
          exp_waits(shadow[1], mode_sh) + 1);
  endtask

  task automatic t_hold_req;
    int sc, rl; bit so, dok, aok, lr;
    int extra = 0;
    do_access(14'h0600, 1, 16'h1234, 16'h0, 1, 0, sc, rl, so, dok, aok, lr);
    check(sc == exp_waits(shadow[3], mode_sh) + 1, "R9 held req length", sc,
          exp_waits(shadow[3], mode_sh) + 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (io_sel) extra++;
    end
    check(extra == 0, "R9 no retrigger", extra, 0);
  endtask

  task automatic t_mid_cfg;
    int sc, rl; bit so, dok, aok, lr;
    int exp = exp_waits(shadow[2], mode_sh) + 1;
    do_access(14'h0400, 0, 16'h0, 16'hBEEF, 0, 1, sc, rl, so, dok, aok, lr);
    check(sc == exp, "R10 length latched", sc, exp);
    shadow[2] = 0;
    do_access(14'h0400, 0, 16'h0, 16'hBEEF, 0, 0, sc, rl, so, dok, aok, lr);
    check(sc == exp_waits(0, mode_sh) + 1, "R10 new code used next", sc, exp_waits(0, mode_sh) + 1);
  endtask

  task automatic t_unused_cfg;
    int d;
    for (int a = 5; a < 8; a++) cfg_write(a, 5);
    for (int a = 5; a < 8; a++) begin
      cfg_read(a, d);
      check(d == 0, "R11 unused address reads 0", d, 0);
    end
    for (int i = 0; i < 4; i++) begin
      cfg_read(i, d);
      check(d == shadow[i], "R11 codes untouched", d, shadow[i]);
    end
    cfg_read(4, d);
    check(d == mode_sh, "R11 stretch untouched", d, mode_sh);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = 7;
    mode_sh = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regions(1);
    shadow[0] = 0; shadow[1] = 3; shadow[2] = 5; shadow[3] = 7;
    for (int i = 0; i < 4; i++) cfg_write(i, shadow[i]);
    cfg_write(4, 0); mode_sh = 0;
    t_regions(0);
    cfg_write(4, 1); mode_sh = 1;
    t_regions(1);
    t_upper_addr();
    t_hold_req();
    t_mid_cfg();
    t_unused_cfg();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule